// File: doc/BRIEF.md
# Top-Boot Flash Block Lock Guard

This block sits beside the command path of a top-boot flash array and decides whether each requested erase or write may proceed. It turns a 20-bit word address into one of 39 erase blocks. The map, counted down from the top of the space, holds two 4K-word boot blocks, then six 4K-word parameter blocks, then thirty-one 32K-word main blocks. It keeps one lock bit per block and a permanent lock bit that freezes all block lock bits. An active-low write-protect pin forces the two boot blocks to count as locked.

Each request is judged against the lock state as it stands before the clock edge. The result appears one cycle later as a one-cycle allow or deny pulse. Lock-bit changes arrive on three strobes and take effect at the same edge. An identifier mode turns the address into a read port for the manufacturer code, the device code, the permanent lock code and the lock code of each block. Array storage and erase timing are handled elsewhere.

Top module: `bootLockGuard`

## Requirements
- R1: `blkIdx` follows the address combinationally. Indices 0 and 1 are the boot blocks at FF000 and FE000. Indices 2..7 are the 4K-word parameter blocks from FD000 down to F8000. Indices 8..38 are the 32K-word main blocks from F0000 down to 00000.
- R2: A block erase (`opCode` 0) or a word write (`opCode` 2) with `opValid` gives a one-cycle `opAllow` in the next cycle if the addressed block's effective lock is clear. It gives a one-cycle `opDeny` instead if that lock is set. A denied request changes no state.
- R3: A full-chip erase (`opCode` 1) is denied if any block's effective lock is set, and allowed otherwise.
- R4: While `wpN` is 0, blocks 0 and 1 count as locked for decisions and for identifier reads. While `wpN` is 1, they follow their stored bits.
- R5: Once the permanent lock is set, it stays set until reset. While it is set, a set-block or clear-all strobe changes no lock bit and raises a one-cycle `lockDeny` in the next cycle. A repeated permanent-lock strobe is accepted without a deny.
- R6: An honoured clear-all strobe clears every block lock bit at the same edge.
- R7: When several lock strobes arrive together, only one is honoured. The permanent-lock strobe wins over the set-block strobe, which wins over the clear-all strobe. The strobes that lose are dropped without a deny.
- R8: With `idMode` at 1, address 00000 reads `MFR_CODE`, 00001 reads `DEV_CODE`, and 00003 reads the permanent lock state in bit 0 with all other bits zero.
- R9: With `idMode` at 1, word offset 2 inside any block reads that block's effective lock in bit 0 with all other bits zero. All other offsets read 0, and with `idMode` at 0, `idData` is 0.
- R10: During reset, `opAllow`, `opDeny` and `lockDeny` are 0. After reset, the lock bits take the `LOCK_INIT` and `PERM_INIT` values, which are all clear by default.
- R11: If an operation and a lock change fall in the same cycle, the operation is judged on the lock state before that edge. The lock change applies at the edge.
- R12: `opCode` 3, or `opValid` at 0, is no request and gives neither `opAllow` nor `opDeny`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 20 | Word address for requests, lock changes and identifier reads |
| opValid | input | 1 | Request strobe for `opCode` |
| opCode | input | 2 | 0 block erase, 1 full-chip erase, 2 word write, 3 none |
| wpN | input | 1 | Write protect, active low, guards the boot blocks |
| setBlkStb | input | 1 | Set the lock bit of the addressed block |
| setPermStb | input | 1 | Set the permanent lock bit |
| clrAllStb | input | 1 | Clear all block lock bits |
| idMode | input | 1 | Select identifier reads on `idData` |
| blkIdx | output | 6 | Index of the addressed block |
| opAllow | output | 1 | Request allowed, one cycle after the request |
| opDeny | output | 1 | Request denied, one cycle after the request |
| lockDeny | output | 1 | Lock change refused because the permanent lock is set |
| idData | output | 16 | Identifier read data |

## Verification
An erase or write request and a lock-bit strobe can land in the same cycle at the same address. The same holds for a request and a clear-all strobe. The bench drives such pairs on purpose, then repeats the request on its own in the next cycle. The first request must be judged on the old lock state and the repeat on the new one. The behavioural model applies the request before the strobe in each clock step, and it is compared with every output once per cycle during the directed phases and a long random run.

// File: rtl/bootLockPkg.sv
package bootLockPkg;

  typedef enum logic [1:0] {
    OP_BLK_ERASE  = 2'd0,
    OP_CHIP_ERASE = 2'd1,
    OP_WORD_WRITE = 2'd2,
    OP_NONE       = 2'd3
  } opKind_e;

  // Lock-state updates from control to datapath, applied at the next edge.
  typedef struct packed {
    logic setBlk;
    logic setPerm;
    logic clrAll;
  } lockStrobe_t;

endpackage

// File: rtl/blockDecode.sv
module blockDecode #(
  parameter int ADDR_W  = 20,
  parameter int BIG_W   = 15,
  parameter int SMALL_W = 12,
  parameter int IDX_W   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  blkIdx,
  output logic [1:0]        offLow,
  output logic              offHiZero
);
  localparam int HI_W      = ADDR_W - BIG_W;
  localparam int SUB_W     = BIG_W - SMALL_W;
  localparam int NUM_SMALL = 1 << SUB_W;
  localparam int NUM_BIG   = (1 << HI_W) - 1;

  logic [HI_W-1:0]  hiField;
  logic [SUB_W-1:0] subField;

  assign hiField  = addr[ADDR_W-1:BIG_W];
  assign subField = addr[BIG_W-1:SMALL_W];
  assign offLow   = addr[1:0];

  // The top big-block slot is split into small blocks counted downward.
  always_comb begin
    if (&hiField) begin
      blkIdx    = IDX_W'(NUM_SMALL - 1) - IDX_W'(subField);
      offHiZero = (addr[SMALL_W-1:2] == '0);
    end else begin
      blkIdx    = IDX_W'(NUM_SMALL + NUM_BIG - 1) - IDX_W'(hiField);
      offHiZero = (addr[BIG_W-1:2] == '0);
    end
  end
endmodule

// File: rtl/lockCtrl.sv
module lockCtrl
  import bootLockPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [1:0]  opCode,
  input  logic        setBlkStb,
  input  logic        setPermStb,
  input  logic        clrAllStb,
  input  logic        effLockTgt,
  input  logic        anyEffLock,
  input  logic        permLock,
  output lockStrobe_t strobe,
  output logic        opAllow,
  output logic        opDeny,
  output logic        lockDeny
);
  opKind_e opKind;
  logic    opReq;
  logic    opBlocked;
  logic    allowNext;
  logic    denyNext;
  logic    lockDenyNext;

  assign opKind = opKind_e'(opCode);
  assign opReq  = opValid && (opKind != OP_NONE);

  always_comb begin
    case (opKind)
      OP_CHIP_ERASE: opBlocked = anyEffLock;
      default:       opBlocked = effLockTgt;
    endcase
    allowNext = opReq && !opBlocked;
    denyNext  = opReq && opBlocked;
  end

  // Single winner among lock strobes: permanent, then set, then clear.
  always_comb begin
    strobe       = '0;
    lockDenyNext = 1'b0;
    if (setPermStb) begin
      strobe.setPerm = 1'b1;
    end else if (setBlkStb) begin
      if (permLock) lockDenyNext = 1'b1;
      else          strobe.setBlk = 1'b1;
    end else if (clrAllStb) begin
      if (permLock) lockDenyNext = 1'b1;
      else          strobe.clrAll = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAllow  <= 1'b0;
      opDeny   <= 1'b0;
      lockDeny <= 1'b0;
    end else begin
      opAllow  <= allowNext;
      opDeny   <= denyNext;
      lockDeny <= lockDenyNext;
    end
  end
endmodule

// File: rtl/lockDatapath.sv
module lockDatapath
  import bootLockPkg::*;
#(
  parameter int          NUM_BLK   = 39,
  parameter int          NUM_BOOT  = 2,
  parameter int          IDX_W     = 6,
  parameter logic [63:0] LOCK_INIT = 64'h0,
  parameter logic        PERM_INIT = 1'b0,
  parameter logic [15:0] MFR_CODE  = 16'h005A,
  parameter logic [15:0] DEV_CODE  = 16'h1C3E
) (
  input  logic               clk,
  input  logic               rstN,
  input  lockStrobe_t        strobe,
  input  logic [IDX_W-1:0]   blkIdx,
  input  logic               wpN,
  input  logic               idMode,
  input  logic [1:0]         offLow,
  input  logic               offHiZero,
  output logic [NUM_BLK-1:0] lockBits,
  output logic               permLock,
  output logic               effLockTgt,
  output logic               anyEffLock,
  output logic [15:0]        idData
);
  logic [NUM_BLK-1:0] effLock;
  logic               bottomBlk;

  for (genvar i = 0; i < NUM_BLK; i++) begin : gLock
    always_ff @(posedge clk) begin
      if (!rstN)                                         lockBits[i] <= LOCK_INIT[i];
      else if (strobe.clrAll)                            lockBits[i] <= 1'b0;
      else if (strobe.setBlk && blkIdx == IDX_W'(i))     lockBits[i] <= 1'b1;
    end
    if (i < NUM_BOOT) begin : gBoot
      assign effLock[i] = lockBits[i] | ~wpN;
    end else begin : gPlain
      assign effLock[i] = lockBits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              permLock <= PERM_INIT;
    else if (strobe.setPerm) permLock <= 1'b1;
  end

  assign effLockTgt = effLock[blkIdx];
  assign anyEffLock = |effLock;
  assign bottomBlk  = (blkIdx == IDX_W'(NUM_BLK - 1));

  always_comb begin
    idData = '0;
    if (idMode && offHiZero) begin
      case (offLow)
        2'd2: idData = {15'd0, effLockTgt};
        2'd0: if (bottomBlk) idData = MFR_CODE;
        2'd1: if (bottomBlk) idData = DEV_CODE;
        2'd3: if (bottomBlk) idData = {15'd0, permLock};
        default: idData = '0;
      endcase
    end
  end
endmodule

// File: rtl/bootLockGuard.sv
module bootLockGuard
  import bootLockPkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          BIG_W     = 15,
  parameter int          SMALL_W   = 12,
  parameter int          NUM_BOOT  = 2,
  parameter logic [63:0] LOCK_INIT = 64'h0,
  parameter logic        PERM_INIT = 1'b0,
  parameter logic [15:0] MFR_CODE  = 16'h005A,
  parameter logic [15:0] DEV_CODE  = 16'h1C3E,
  localparam int NUM_BLK = (1 << (BIG_W - SMALL_W)) + (1 << (ADDR_W - BIG_W)) - 1,
  localparam int IDX_W   = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic              wpN,
  input  logic              setBlkStb,
  input  logic              setPermStb,
  input  logic              clrAllStb,
  input  logic              idMode,
  output logic [IDX_W-1:0]  blkIdx,
  output logic              opAllow,
  output logic              opDeny,
  output logic              lockDeny,
  output logic [15:0]       idData
);
  lockStrobe_t        strobe;
  logic [1:0]         offLow;
  logic               offHiZero;
  logic [NUM_BLK-1:0] lockBits;
  logic               permLock;
  logic               effLockTgt;
  logic               anyEffLock;

  blockDecode #(
    .ADDR_W(ADDR_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W), .IDX_W(IDX_W)
  ) uDecode (
    .addr(addr), .blkIdx(blkIdx), .offLow(offLow), .offHiZero(offHiZero)
  );

  lockCtrl uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .setBlkStb(setBlkStb), .setPermStb(setPermStb), .clrAllStb(clrAllStb),
    .effLockTgt(effLockTgt), .anyEffLock(anyEffLock), .permLock(permLock),
    .strobe(strobe), .opAllow(opAllow), .opDeny(opDeny), .lockDeny(lockDeny)
  );

  lockDatapath #(
    .NUM_BLK(NUM_BLK), .NUM_BOOT(NUM_BOOT), .IDX_W(IDX_W),
    .LOCK_INIT(LOCK_INIT), .PERM_INIT(PERM_INIT),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blkIdx(blkIdx), .wpN(wpN),
    .idMode(idMode), .offLow(offLow), .offHiZero(offHiZero),
    .lockBits(lockBits), .permLock(permLock), .effLockTgt(effLockTgt),
    .anyEffLock(anyEffLock), .idData(idData)
  );
endmodule

// File: rtl/bootLockGuardChk.sv
module bootLockGuardChk #(
  parameter int NUM_BLK  = 39,
  parameter int NUM_BOOT = 2,
  parameter int IDX_W    = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               opValid,
  input logic [1:0]         opCode,
  input logic               wpN,
  input logic               setBlkStb,
  input logic               setPermStb,
  input logic               clrAllStb,
  input logic [IDX_W-1:0]   blkIdx,
  input logic               opAllow,
  input logic               opDeny,
  input logic               lockDeny,
  input logic [NUM_BLK-1:0] lockBits,
  input logic               permLock
);
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    blkIdx < IDX_W'(NUM_BLK)); // R1

  AST_ALLOW_DENY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opAllow, opDeny})); // R2

  AST_WP_BOOT_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (!wpN && opValid && (opCode == 2'd0 || opCode == 2'd2) && blkIdx < IDX_W'(NUM_BOOT))
    |=> opDeny); // R4

  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    permLock |=> permLock); // R5

  AST_PERM_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    permLock |=> $stable(lockBits)); // R5

  AST_LOCKDENY_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    lockDeny |-> lockBits == $past(lockBits)); // R5

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (clrAllStb && !setBlkStb && !setPermStb && !permLock) |=> lockBits == '0); // R6

  AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opCode == 2'd3) |=> (!opAllow && !opDeny)); // R12
endmodule

bind bootLockGuard bootLockGuardChk #(
  .NUM_BLK(NUM_BLK), .NUM_BOOT(NUM_BOOT), .IDX_W(IDX_W)
) chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .wpN(wpN),
  .setBlkStb(setBlkStb), .setPermStb(setPermStb), .clrAllStb(clrAllStb),
  .blkIdx(blkIdx), .opAllow(opAllow), .opDeny(opDeny), .lockDeny(lockDeny),
  .lockBits(lockBits), .permLock(permLock)
);

// File: tb/tb_bootLockGuard.sv
`timescale 1ns/1ps
module tb_bootLockGuard;
  localparam logic [15:0] MFR = 16'h005A;
  localparam logic [15:0] DEV = 16'h1C3E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [19:0] addr = '0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'd3;
  logic        wpN = 1'b1;
  logic        setBlkStb = 1'b0, setPermStb = 1'b0, clrAllStb = 1'b0, idMode = 1'b0;
  wire  [5:0]  blkIdx;
  wire         opAllow, opDeny, lockDeny;
  wire  [15:0] idData;

  bootLockGuard #(.MFR_CODE(MFR), .DEV_CODE(DEV)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .opValid(opValid), .opCode(opCode),
    .wpN(wpN), .setBlkStb(setBlkStb), .setPermStb(setPermStb),
    .clrAllStb(clrAllStb), .idMode(idMode), .blkIdx(blkIdx),
    .opAllow(opAllow), .opDeny(opDeny), .lockDeny(lockDeny), .idData(idData)
  );

  bit    mLock[39];
  bit    mPerm;
  bit    eAllow, eDeny, eLockDeny;
  int    nVec = 0, nBad = 0;
  string curReq = "R10";

  function automatic int refIdx(logic [19:0] a);
    if (a >= 20'hF8000) return int'((20'hFFFFF - a) >> 12);
    return 8 + int'((20'hF7FFF - a) >> 15);
  endfunction

  function automatic logic [19:0] baseOf(int i);
    if (i < 8) return 20'hFF000 - 20'(i * 'h1000);
    return 20'hF0000 - 20'((i - 8) * 'h8000);
  endfunction

  function automatic logic [19:0] sizeOf(int i);
    return (i < 8) ? 20'h1000 : 20'h8000;
  endfunction

  function automatic bit refEff(int i);
    return mLock[i] || (!wpN && i < 2);
  endfunction

  function automatic logic [15:0] refId(logic [19:0] a);
    int rel;
    if (!idMode) return 16'h0;
    if (a == 20'h0) return MFR;
    if (a == 20'h1) return DEV;
    if (a == 20'h3) return {15'd0, mPerm};
    rel = (a >= 20'hF8000) ? int'(a & 20'hFFF) : int'(a & 20'h7FFF);
    if (rel == 2) return {15'd0, refEff(refIdx(a))};
    return 16'h0;
  endfunction

  // Reference model: request judged first, lock change applied after (R11).
  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mLock[i]) mLock[i] = 1'b0;
      mPerm = 1'b0; eAllow = 1'b0; eDeny = 1'b0; eLockDeny = 1'b0;
    end else begin
      bit anyL;
      int t;
      bit blk;
      anyL = 1'b0;
      t = refIdx(addr);
      for (int i = 0; i < 39; i++) if (refEff(i)) anyL = 1'b1;
      eAllow = 1'b0; eDeny = 1'b0; eLockDeny = 1'b0;
      if (opValid && opCode != 2'd3) begin
        blk = (opCode == 2'd1) ? anyL : refEff(t);
        eAllow = !blk;
        eDeny = blk;
      end
      if (setPermStb) mPerm = 1'b1;
      else if (setBlkStb) begin
        if (mPerm) eLockDeny = 1'b1; else mLock[t] = 1'b1;
      end else if (clrAllStb) begin
        if (mPerm) eLockDeny = 1'b1;
        else foreach (mLock[i]) mLock[i] = 1'b0;
      end
    end
  end

  task automatic cmp(string tag, string nm, logic [15:0] act, logic [15:0] exp);
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic apply(logic [19:0] a, logic v, logic [1:0] c, logic sb = 0,
                       logic sp = 0, logic ca = 0, logic idm = 0, logic wp = 1);
    @(negedge clk);
    addr = a; opValid = v; opCode = c; setBlkStb = sb; setPermStb = sp;
    clrAllStb = ca; idMode = idm; wpN = wp;
    #1;
    nVec++;
    cmp("R1", "blkIdx", 16'(blkIdx), 16'(refIdx(a)));
    cmp(curReq, "opAllow", 16'(opAllow), 16'(eAllow));
    cmp(curReq, "opDeny", 16'(opDeny), 16'(eDeny));
    cmp(curReq, "lockDeny", 16'(lockDeny), 16'(eLockDeny));
    cmp(curReq, "idData", idData, refId(a));
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    // R10: reset state, lock codes read clear
    curReq = "R10";
    apply(20'h0, 1'b1, 2'd0);
    apply(20'hFF002, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'h3, 1'b0, 2'd3, 0, 0, 0, 1);
    rstN = 1'b1;
    apply(20'hF0002, 1'b0, 2'd3, 0, 0, 0, 1);

    // R1: every block's first and last word
    curReq = "R1";
    for (int i = 0; i < 39; i++) begin
      apply(baseOf(i), 1'b0, 2'd3);
      apply(baseOf(i) + sizeOf(i) - 20'h1, 1'b0, 2'd3);
    end

    // R2: allow on clear lock, deny on set lock
    curReq = "R2";
    apply(baseOf(5), 1'b1, 2'd0);
    apply(baseOf(20) + 20'h7, 1'b1, 2'd2);
    apply(baseOf(5), 1'b0, 2'd3, 1);
    apply(baseOf(5) + 20'h10, 1'b1, 2'd0);
    apply(baseOf(5) + 20'h3, 1'b1, 2'd2);
    apply(baseOf(6), 1'b1, 2'd2);
    apply(20'h0, 1'b0, 2'd3);

    // R3: chip erase blocked by any lock
    curReq = "R3";
    apply(20'h12345, 1'b1, 2'd1);
    apply(20'h0, 1'b0, 2'd3);

    // R6: clear all, then chip erase passes
    curReq = "R6";
    apply(baseOf(0), 1'b0, 2'd3, 1);
    apply(baseOf(12), 1'b0, 2'd3, 1);
    apply(baseOf(38), 1'b0, 2'd3, 1);
    apply(baseOf(12) + 20'h2, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'h2, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'h0, 1'b0, 2'd3, 0, 0, 1);
    apply(baseOf(12) + 20'h2, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'h12345, 1'b1, 2'd1);
    apply(20'h0, 1'b0, 2'd3);

    // R4: write protect forces boot blocks locked
    curReq = "R4";
    apply(baseOf(0), 1'b1, 2'd0, 0, 0, 0, 0, 0);
    apply(baseOf(1) + 20'h55, 1'b1, 2'd2, 0, 0, 0, 0, 0);
    apply(baseOf(2), 1'b1, 2'd0, 0, 0, 0, 0, 0);
    apply(20'h4000, 1'b1, 2'd1, 0, 0, 0, 0, 0);
    apply(baseOf(0) + 20'h2, 1'b0, 2'd3, 0, 0, 0, 1, 0);
    apply(baseOf(0), 1'b1, 2'd0);
    apply(20'h4000, 1'b1, 2'd1);
    apply(baseOf(0) + 20'h2, 1'b0, 2'd3, 0, 0, 0, 1);

    // R8 / R9: identifier reads and reserved offsets
    curReq = "R8";
    apply(20'h0, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'h1, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'h3, 1'b0, 2'd3, 0, 0, 0, 1);
    curReq = "R9";
    apply(20'hFF000, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'hFF001, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'hFF003, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'h00004, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'hF0001, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'h0, 1'b0, 2'd3);

    // R11: request and lock change in the same cycle
    curReq = "R11";
    apply(baseOf(10), 1'b1, 2'd0, 1);
    apply(baseOf(10), 1'b1, 2'd0);
    apply(baseOf(10) + 20'h9, 1'b1, 2'd2, 0, 0, 1);
    apply(baseOf(10) + 20'h9, 1'b1, 2'd2);
    apply(20'h0, 1'b0, 2'd3);

    // R7: strobe priority
    curReq = "R7";
    apply(baseOf(3), 1'b0, 2'd3, 1, 0, 1);
    apply(baseOf(3) + 20'h2, 1'b0, 2'd3, 0, 0, 0, 1);
    // R12: reserved code is no request
    curReq = "R12";
    apply(baseOf(3), 1'b1, 2'd3);
    apply(baseOf(4), 1'b0, 2'd0);
    apply(baseOf(4), 1'b0, 2'd3);
    curReq = "R7";
    apply(baseOf(7), 1'b0, 2'd3, 1, 1, 0);
    apply(baseOf(7) + 20'h2, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(20'h3, 1'b0, 2'd3, 0, 0, 0, 1);

    // R5: permanent lock freezes lock bits
    curReq = "R5";
    apply(baseOf(9), 1'b0, 2'd3, 1);
    apply(20'h0, 1'b0, 2'd3, 0, 0, 1);
    apply(baseOf(3) + 20'h2, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(baseOf(9) + 20'h2, 1'b0, 2'd3, 0, 0, 0, 1);
    apply(baseOf(3), 1'b1, 2'd0);
    apply(20'h0, 1'b0, 2'd3, 0, 1);
    apply(20'h0, 1'b0, 2'd3);

    // Random mix after a fresh reset
    curReq = "R2";
    @(negedge clk) rstN = 1'b0;
    apply(20'h0, 1'b0, 2'd3);
    rstN = 1'b1;
    for (int k = 0; k < 1500; k++) begin
      logic [19:0] a;
      int b;
      b = int'($urandom_range(0, 38));
      a = ($urandom_range(0, 1) == 1) ? baseOf(b) + 20'($urandom_range(0, 3))
                                      : 20'($urandom);
      apply(a, 1'($urandom), 2'($urandom), 1'($urandom_range(0, 5) == 0),
            1'($urandom_range(0, 300) == 0), 1'($urandom_range(0, 7) == 0),
            1'($urandom), 1'($urandom_range(0, 3) != 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule